// File: doc/BRIEF.md
# Odd-Even Cell Balancing Scheduler

This block decides when the cells of a series battery stack are bled toward each other, and which cells are bled at each moment. It receives one comparator flag per cell that says whether the cell sits above the balance threshold. It also receives the number of cells that are fitted and three inhibit conditions: an open sense wire, a discharge over-temperature, and the low-power state. A one-clock tick that arrives every millisecond paces all of its timing.

Balancing is allowed only while the fitted cells disagree, meaning at least one is above the threshold and at least one is below it. That disagreement must last for a qualification delay before balancing starts. Once running, the block repeats a fixed frame of equal slots: a sampling slot, a settling slot, and then alternating odd and even bleed slots. During the sampling and settling slots no bleed current flows, so the voltage measurement stays clean. Bleeding odd-numbered and even-numbered cells in separate slots means two neighbouring cells are never bled at once. The set of cells to bleed is frozen from the flags at the end of each sampling slot.

The block has no data stream, so every pin is a plain level or pulse with no handshake. The caller supplies one clean tick per millisecond, and the bleed outputs drive the per-cell bleed switches directly.

Top module: `bal_sched`

## Requirements
- R1: After reset all bleed enables are 0 and no qualification time has built up.
- R2: Balancing starts on the START_MS-th consecutive tick during which the fitted cells are mixed (at least one flag 1 and at least one flag 0) and no inhibit is active. One tick fewer starts nothing. The first slot after the start is a sampling slot.
- R3: When every fitted cell flag is 0, all bleed enables are 0 from the next clock, and qualification restarts from zero.
- R4: When every fitted cell flag is 1, all bleed enables are 0 from the next clock, and qualification restarts from zero.
- R5: While wire_open, dis_hot or low_power is 1, all bleed enables are 0 from the next clock, and balancing stays stopped.
- R6: A running frame has 2+2*BAL_PAIRS slots of SLOT_MS ticks each, in the order sample, settle, then odd and even bleed slots alternating, starting with odd. No enable is set in the sample or settle slots.
- R7: In an odd slot only bits 0,2,4,… (cells 1,3,5,…) may be set. In an even slot only bits 1,3,5,… may be set. Two adjacent bits are never set together.
- R8: The set of cells to bleed is the flags ANDed with the fitted-cell mask, captured on the tick that ends the sampling slot. Flag changes after that capture do not alter the enables until the next capture, as long as no stop condition occurs.
- R9: A cell whose index (0-based) is at least cell_count never gets an enable. cell_count is the binary number of fitted cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse, once per millisecond |
| above | input | N_CELLS | Per-cell flag, 1 = cell above balance threshold; bit 0 is cell 1 |
| cell_count | input | CW | Number of fitted cells, binary |
| wire_open | input | 1 | Open sense-wire protection active |
| dis_hot | input | 1 | Discharge over-temperature protection active |
| low_power | input | 1 | Low-power state active |
| bleed_en | output | N_CELLS | Per-cell bleed switch enable |

## Verification
The bench builds the block with N_CELLS=7, SLOT_MS=3 and START_MS=2, and keeps the default of two odd/even pairs. That gives an 18-tick frame, so the run passes through many complete frames and many captures, as well as stops and restarts in every slot position. With seven cells and cell_count driven between 4 and 7, both parity groups are present, and flags set on unfitted cells show whether the count mask holds. Short slot and qualification lengths let random flag and inhibit activity land on the capture tick and on the qualification boundary often.

// File: rtl/bal_pkg.sv
package bal_pkg;
  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_SETTLE = 2'd1,
    PH_ODD    = 2'd2,
    PH_EVEN   = 2'd3
  } phase_t;
endpackage

// File: rtl/bal_qualify.sv
module bal_qualify #(
  parameter int N_CELLS  = 7,
  parameter int START_MS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [N_CELLS-1:0] above,
  input  logic [N_CELLS-1:0] cell_mask,
  input  logic               inhibit,
  output logic               run,
  output logic               stop
);
  localparam int QW = (START_MS < 2) ? 1 : $clog2(START_MS);

  logic [QW-1:0] qcnt;
  logic any_hi, any_lo;

  assign any_hi = |(above & cell_mask);
  assign any_lo = |(~above & cell_mask);
  assign stop   = !(any_hi && any_lo) || inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      qcnt <= '0;
    end else if (stop) begin
      run  <= 1'b0;
      qcnt <= '0;
    end else if (!run && tick) begin
      if (qcnt == QW'(START_MS - 1)) begin
        run  <= 1'b1;
        qcnt <= '0;
      end else begin
        qcnt <= qcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bal_frame.sv
module bal_frame
  import bal_pkg::*;
#(
  parameter int SLOT_MS   = 8,
  parameter int BAL_PAIRS = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   run,
  output phase_t phase,
  output logic   sample_end
);
  localparam int NSLOT = 2 + 2 * BAL_PAIRS;
  localparam int MW    = (SLOT_MS < 2) ? 1 : $clog2(SLOT_MS);
  localparam int SW    = $clog2(NSLOT);

  logic [MW-1:0] ms;
  logic [SW-1:0] slot;
  logic          slot_last_ms;

  assign slot_last_ms = (ms == MW'(SLOT_MS - 1));
  assign sample_end   = run && tick && (slot == '0) && slot_last_ms;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms   <= '0;
      slot <= '0;
    end else if (!run) begin
      ms   <= '0;
      slot <= '0;
    end else if (tick) begin
      if (slot_last_ms) begin
        ms   <= '0;
        slot <= (slot == SW'(NSLOT - 1)) ? '0 : slot + 1'b1;
      end else begin
        ms <= ms + 1'b1;
      end
    end
  end

  always_comb begin
    if (slot == SW'(0))      phase = PH_SAMPLE;
    else if (slot == SW'(1)) phase = PH_SETTLE;
    else if (!slot[0])       phase = PH_ODD;
    else                     phase = PH_EVEN;
  end
endmodule

// File: rtl/bal_gate.sv
module bal_gate
  import bal_pkg::*;
#(
  parameter int N_CELLS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               sample_end,
  input  phase_t             phase,
  input  logic [N_CELLS-1:0] above,
  input  logic [N_CELLS-1:0] cell_mask,
  output logic [N_CELLS-1:0] bleed_en
);
  logic [N_CELLS-1:0] odd_m, even_m, held;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_par
    assign odd_m[i]  = (i % 2 == 0);
    assign even_m[i] = (i % 2 == 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          held <= '0;
    else if (!run)       held <= '0;
    else if (sample_end) held <= above & cell_mask;
  end

  always_comb begin
    bleed_en = '0;
    if (run) begin
      case (phase)
        PH_ODD:  bleed_en = held & odd_m & cell_mask;
        PH_EVEN: bleed_en = held & even_m & cell_mask;
        default: bleed_en = '0;
      endcase
    end
  end
endmodule

// File: rtl/bal_sched.sv
module bal_sched
  import bal_pkg::*;
#(
  parameter int N_CELLS   = 7,
  parameter int CW        = $clog2(N_CELLS + 1),
  parameter int SLOT_MS   = 8,
  parameter int BAL_PAIRS = 2,
  parameter int START_MS  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [N_CELLS-1:0] above,
  input  logic [CW-1:0]      cell_count,
  input  logic               wire_open,
  input  logic               dis_hot,
  input  logic               low_power,
  output logic [N_CELLS-1:0] bleed_en
);
  logic [N_CELLS-1:0] cell_mask;
  logic               run, stop, sample_end;
  phase_t             phase;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_mask
    assign cell_mask[i] = (cell_count > CW'(i));
  end

  bal_qualify #(.N_CELLS(N_CELLS), .START_MS(START_MS)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick), .above(above),
    .cell_mask(cell_mask), .inhibit(wire_open | dis_hot | low_power),
    .run(run), .stop(stop)
  );

  bal_frame #(.SLOT_MS(SLOT_MS), .BAL_PAIRS(BAL_PAIRS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .phase(phase), .sample_end(sample_end)
  );

  bal_gate #(.N_CELLS(N_CELLS)) u_gate (
    .clk(clk), .rst_n(rst_n), .run(run), .sample_end(sample_end),
    .phase(phase), .above(above), .cell_mask(cell_mask), .bleed_en(bleed_en)
  );
endmodule

// File: rtl/bal_sched_chk.sv
module bal_sched_chk
  import bal_pkg::*;
#(
  parameter int N_CELLS = 7,
  parameter int CW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CELLS-1:0] above,
  input logic [CW-1:0]      cell_count,
  input logic               wire_open,
  input logic               dis_hot,
  input logic               low_power,
  input phase_t             phase,
  input logic [N_CELLS-1:0] bleed_en
);
  logic [N_CELLS-1:0] fit, even_m;
  for (genvar i = 0; i < N_CELLS; i++) begin : g_m
    assign fit[i]    = (cell_count > CW'(i));
    assign even_m[i] = (i % 2 == 1);
  end

  a_r3_all_low_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ((above & fit) == '0) |=> (bleed_en == '0));
  a_r4_all_high_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ((above | ~fit) == '1) |=> (bleed_en == '0));
  a_r5_inhibit_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (wire_open || dis_hot || low_power) |=> (bleed_en == '0));
  a_r6_quiet_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SAMPLE || phase == PH_SETTLE) |-> (bleed_en == '0));
  a_r7_odd_only: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ODD) |-> ((bleed_en & even_m) == '0));
  a_r7_no_neighbours: assert property (@(posedge clk) disable iff (!rst_n)
    ((bleed_en & (bleed_en >> 1)) == '0));
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((bleed_en & ~fit) == '0));
endmodule

bind bal_sched bal_sched_chk #(.N_CELLS(N_CELLS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .above(above), .cell_count(cell_count),
  .wire_open(wire_open), .dis_hot(dis_hot), .low_power(low_power),
  .phase(phase), .bleed_en(bleed_en)
);

// File: tb/tb_bal_sched.sv
module tb_bal_sched;
  localparam int PERIOD = 10;
  localparam int N      = 7;
  localparam int SLOT   = 3;
  localparam int START  = 2;
  localparam int NSLOT  = 6;
  localparam int FRAME  = SLOT * NSLOT;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [N-1:0] above = '0;
  logic [2:0] cell_count = 3'd7;
  logic wire_open = 0, dis_hot = 0, low_power = 0;
  logic [N-1:0] bleed_en;

  int errs = 0, checks = 0;
  bit done = 0;
  string ctx = "R1";

  bit m_run = 0;
  int m_q = 0, m_pos = 0;
  logic [N-1:0] m_held = '0;

  always #(PERIOD/2) clk = ~clk;

  bal_sched #(.N_CELLS(N), .CW(3), .SLOT_MS(SLOT), .BAL_PAIRS(2), .START_MS(START)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .above(above), .cell_count(cell_count),
    .wire_open(wire_open), .dis_hot(dis_hot), .low_power(low_power), .bleed_en(bleed_en));

  function automatic logic [N-1:0] fit_mask(input logic [2:0] c);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) m[i] = (c > 3'(i));
    return m;
  endfunction

  function automatic logic [N-1:0] par_mask(input bit odd);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) m[i] = odd ? (i % 2 == 0) : (i % 2 == 1);
    return m;
  endfunction

  function automatic logic [N-1:0] expect_bleed();
    int s;
    if (!m_run) return '0;
    s = (m_pos / SLOT) % NSLOT;
    if (s < 2) return '0;
    return m_held & par_mask(s % 2 == 0) & fit_mask(cell_count);
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: bleed_en actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input bit tk, input logic [N-1:0] ab, input logic [2:0] cn,
                      input bit ow, input bit dh, input bit lp);
    logic [N-1:0] m;
    bit stp;
    @(negedge clk);
    tick = tk; above = ab; cell_count = cn;
    wire_open = ow; dis_hot = dh; low_power = lp;
    m = fit_mask(cn);
    stp = !((|(ab & m)) && (|(~ab & m))) || ow || dh || lp;
    if (stp) begin
      m_run = 0; m_q = 0; m_pos = 0; m_held = '0;
    end else if (!m_run && tk) begin
      if (m_q == START - 1) begin m_run = 1; m_pos = 0; m_held = '0; m_q = 0; end
      else m_q++;
    end else if (m_run && tk) begin
      if (m_pos % FRAME == SLOT - 1) m_held = ab & m;
      m_pos++;
    end
    @(posedge clk); #1;
    check(ctx, bleed_en, expect_bleed());
    if ((bleed_en & (bleed_en >> 1)) != '0) check("R7 adjacency", bleed_en, '0);
    if ((bleed_en & ~fit_mask(cn)) != '0) check("R9 beyond count", bleed_en & ~fit_mask(cn), '0);
  endtask

  task automatic ticks(input int n, input logic [N-1:0] ab, input logic [2:0] cn);
    for (int k = 0; k < n; k++) begin
      step(1, ab, cn, 0, 0, 0);
      step(0, ab, cn, 0, 0, 0);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0011));
    #(PERIOD * 3);
    check("R1 in reset", bleed_en, '0);
    @(negedge clk); rst_n = 1;
    step(0, 7'b0000101, 3'd7, 0, 0, 0);
    check("R1 after reset", bleed_en, '0);

    ctx = "R2";
    ticks(START - 1, 7'b0000101, 3'd7);
    check("R2 one tick short", bleed_en, '0);
    ticks(1, 7'b0000101, 3'd7);
    ctx = "R6";
    ticks(2 * SLOT, 7'b0000101, 3'd7);
    ctx = "R7";
    ticks(1, 7'b0000101, 3'd7);
    check("R7 odd slot cells 1,3", bleed_en, 7'b0000101);
    ctx = "R8";
    ticks(1, 7'b0000110, 3'd7);
    check("R8 held after capture", bleed_en, 7'b0000101);
    ticks(SLOT + 2 * SLOT, 7'b0000110, 3'd7);
    ticks(FRAME, 7'b0000110, 3'd7);
    ctx = "R3";
    step(0, 7'b0000000, 3'd7, 0, 0, 0);
    check("R3 all low", bleed_en, '0);

    ctx = "R4";
    ticks(START + 3 * SLOT, 7'b0101010, 3'd7);
    step(0, 7'b1111111, 3'd7, 0, 0, 0);
    check("R4 all high", bleed_en, '0);

    ctx = "R5";
    ticks(START + 3 * SLOT, 7'b0000011, 3'd7);
    step(0, 7'b0000011, 3'd7, 1, 0, 0);
    check("R5 open wire", bleed_en, '0);
    ticks(START + 3 * SLOT, 7'b0000011, 3'd7);
    step(0, 7'b0000011, 3'd7, 0, 1, 0);
    check("R5 discharge hot", bleed_en, '0);
    ticks(START + 3 * SLOT, 7'b0000011, 3'd7);
    step(1, 7'b0000011, 3'd7, 0, 0, 1);
    check("R5 low power", bleed_en, '0);

    ctx = "R9";
    ticks(START + 2 * SLOT + 1, 7'b1010001, 3'd4);
    check("R9 count 4 odd slot", bleed_en, 7'b0000001);
    ticks(FRAME, 7'b1010001, 3'd4);

    for (int n = 0; n < 6000; n++) begin
      logic [N-1:0] ab;
      logic [2:0] cn;
      ctx = "R6/R7/R8 random";
      ab = above; cn = cell_count;
      if ($urandom % 40 == 0) ab = N'($urandom);
      if ($urandom % 300 == 0) cn = 3'(4 + $urandom % 4);
      step($urandom % 2, ab, cn, ($urandom % 150 == 0), ($urandom % 150 == 0),
           ($urandom % 150 == 0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule